// File: doc/BRIEF.md
# Framed Serial Port with Clock Dividers

This block is the synchronous serial link between a converter front end and a DSP host. Everything runs on one master clock. Two programmable dividers, a prescaler and a serial-clock divider, produce a serial clock whose period is their product. A third counter produces a sample-rate strobe at one of four rates. Each strobe starts one outgoing 16-bit word. The word is preceded by a one-bit-wide frame sync that is high for the serial-clock period just before the MSB. Incoming words are framed the same way and are handed over on a parallel bus together with a single-cycle valid pulse.

A host enable input may change at any time. While it is low:
- the serial clock stops,
- both output lines report that they are not driven,
- the serial inputs are ignored.

Dropping the enable keeps the divider settings and the last received word. It clears every timing counter, so the port starts from a clean phase when the enable returns.

Top module: `framed_serial_port`

## Requirements
- R1: The divider fields are encoded as follows: field value m of `cfg_mdiv` divides by m+1, and field value s of `cfg_sdiv` divides by 2^(s+1). `ser_clk` then has a period of (m+1)·2^(s+1) master-clock cycles and is high for exactly half of it.
- R2: `rate_stb` is a one-cycle pulse. For field value r of `cfg_rate` it repeats every 256·2^r master-clock cycles, giving 256, 512, 1024 or 2048 cycles.
- R3: Each strobe accepted while no word is in flight sends the `tx_word` value present at the strobe. `tx_sync` is high from one `ser_clk` rising edge to the next. The MSB follows on the next rising edge, and the 16 bits go out MSB first, one per rising edge.
- R4: `tx_dat_oe` is high only during the 16 data-bit periods. It is never high together with `tx_sync`.
- R5: If `rx_sync` is sampled high on a falling edge of `ser_clk` while no word is being received, the next 16 falling edges sample `rx_dat`, MSB first. `rx_word` changes only together with a one-cycle `rx_valid` pulse, which rises at the edge that samples the 16th bit.
- R6: `rx_sync` high while a word is being received has no effect: the word completes intact and produces exactly one `rx_valid` pulse.
- R7: While `host_en` is low, the following all stay low, and toggling `rx_dat`/`rx_sync` produces no `rx_valid`:
  - `ser_clk`
  - `tx_dat_oe`
  - `tx_sync_oe`
  - `rate_stb`
  - `rx_valid`
- R8: When `host_en` returns high, the divider settings and `rx_word` keep their earlier values. The rate counter restarts from zero, so the first `rate_stb` is seen 256·2^r + 1 master-clock cycles after `host_en` rises; this includes the two-stage enable synchronizer.
- R9: While `rst_n` is low, all outputs and `rx_word` are 0. After reset the divider fields are all zero, giving a 2-cycle `ser_clk` and a 256-cycle strobe.
- R10: The divider fields are stored only on a cycle with `cfg_we` high. Changing them with `cfg_we` low leaves `ser_clk` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Asynchronous port enable |
| cfg_we | input | 1 | Store the divider fields this cycle |
| cfg_mdiv | input | 3 | Prescaler field (divide by value+1) |
| cfg_sdiv | input | 2 | Serial-clock divider field (divide by 2^(value+1)) |
| cfg_rate | input | 2 | Sample-rate field (256·2^value cycles) |
| tx_word | input | 16 | Word to transmit, taken at an accepted strobe |
| rx_dat | input | 1 | Serial receive data |
| rx_sync | input | 1 | Receive frame sync |
| ser_clk | output | 1 | Serial clock |
| tx_dat | output | 1 | Serial transmit data |
| tx_dat_oe | output | 1 | Transmit data is driven (high-impedance when low) |
| tx_sync | output | 1 | Transmit frame sync |
| tx_sync_oe | output | 1 | Transmit frame sync is driven (high-impedance when low) |
| rate_stb | output | 1 | Sample-rate strobe |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
The restart after the enable returns is the situation hardest to reach from the ports. The counters must have been cleared while the stored settings and the received word survive, and that can only be seen as an exact cycle count to the first strobe. The bench therefore receives a word, drops the enable for several hundred cycles while it wiggles the serial inputs, and then raises the enable on a known clock edge. It then counts the cycles to the first strobe, re-measures the serial-clock period, and compares the held word. A frame sync that stays high throughout a word is reached by a host model that holds the sync line up during every data bit.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  // Divider field widths
  localparam int MDIV_W = 3;
  localparam int SDIV_W = 2;
  localparam int RATE_W = 2;

  typedef struct packed {
    logic [MDIV_W-1:0] mdiv;
    logic [SDIV_W-1:0] sdiv;
    logic [RATE_W-1:0] rate;
  } fsp_cfg_t;

  localparam fsp_cfg_t CFG_RESET = '{mdiv: '0, sdiv: '0, rate: '0};

endpackage

// File: rtl/fsp_clkgen.sv
module fsp_clkgen
  import fsp_pkg::*;
#(
  parameter int RATE_BASE_LOG2 = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  fsp_cfg_t cfg,
  output logic     ser_clk,
  output logic     rise_ev,
  output logic     fall_ev,
  output logic     rate_stb
);

  localparam int HALF_W = (1 << SDIV_W);
  localparam int RCNT_W = RATE_BASE_LOG2 + (1 << RATE_W) - 1;

  logic [MDIV_W-1:0] pre_q, pre_d;
  logic [HALF_W-1:0] half_q, half_d, half_lim;
  logic [RCNT_W-1:0] rate_q, rate_d, rate_lim;
  logic              sclk_q, sclk_d;
  logic              tick, toggle;

  always_comb begin
    half_lim = HALF_W'((32'(1) << cfg.sdiv) - 1);
    rate_lim = RCNT_W'((32'(1) << (RATE_BASE_LOG2 + int'(cfg.rate))) - 1);
    tick     = (pre_q >= cfg.mdiv);
    toggle   = tick && (half_q >= half_lim);
    pre_d    = pre_q;
    half_d   = half_q;
    sclk_d   = sclk_q;
    rate_d   = rate_q;
    if (!run) begin
      pre_d  = '0;
      half_d = '0;
      sclk_d = 1'b0;
      rate_d = '0;
    end else begin
      pre_d = tick ? '0 : pre_q + MDIV_W'(1);
      if (tick) begin
        half_d = toggle ? '0 : half_q + HALF_W'(1);
      end
      if (toggle) begin
        sclk_d = !sclk_q;
      end
      rate_d = (rate_q >= rate_lim) ? '0 : rate_q + RCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      half_q <= '0;
      sclk_q <= 1'b0;
      rate_q <= '0;
    end else begin
      pre_q  <= pre_d;
      half_q <= half_d;
      sclk_q <= sclk_d;
      rate_q <= rate_d;
    end
  end

  assign ser_clk  = sclk_q;
  assign rise_ev  = run && toggle && !sclk_q;
  assign fall_ev  = run && toggle && sclk_q;
  assign rate_stb = run && (rate_q >= rate_lim);

endmodule

// File: rtl/fsp_tx.sv
module fsp_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              rise_ev,
  input  logic              rate_stb,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_dat,
  output logic              tx_dat_oe,
  output logic              tx_sync,
  output logic              tx_sync_oe
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              pend_q, pend_d;
  logic              fs_q, fs_d;
  logic              act_q, act_d;
  logic              bit_q, bit_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic [WORD_W-1:0] shr_q, shr_d;
  logic              busy;

  always_comb begin
    pend_d = pend_q;
    fs_d   = fs_q;
    act_d  = act_q;
    bit_d  = bit_q;
    left_d = left_q;
    shr_d  = shr_q;
    busy   = pend_q || fs_q || act_q;
    if (!run) begin
      pend_d = 1'b0;
      fs_d   = 1'b0;
      act_d  = 1'b0;
      bit_d  = 1'b0;
      left_d = '0;
    end else begin
      if (rise_ev) begin
        fs_d   = pend_q;
        pend_d = 1'b0;
        if (fs_q || (act_q && (left_q != '0))) begin
          act_d  = 1'b1;
          bit_d  = shr_q[WORD_W-1];
          shr_d  = {shr_q[WORD_W-2:0], 1'b0};
          left_d = fs_q ? CNT_W'(WORD_W - 1) : left_q - CNT_W'(1);
        end else begin
          act_d = 1'b0;
          bit_d = 1'b0;
        end
      end
      if (rate_stb && !busy) begin
        pend_d = 1'b1;
        shr_d  = tx_word;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      fs_q   <= 1'b0;
      act_q  <= 1'b0;
      bit_q  <= 1'b0;
      left_q <= '0;
      shr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      fs_q   <= fs_d;
      act_q  <= act_d;
      bit_q  <= bit_d;
      left_q <= left_d;
      shr_q  <= shr_d;
    end
  end

  assign tx_dat     = bit_q;
  assign tx_dat_oe  = run && act_q;
  assign tx_sync    = fs_q;
  assign tx_sync_oe = run;

endmodule

// File: rtl/fsp_rx.sv
module fsp_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fall_ev,
  input  logic              rx_dat,
  input  logic              rx_sync,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  left_q, left_d;
  logic [WORD_W-1:0] shr_q, shr_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;

  always_comb begin
    left_d = left_q;
    shr_d  = shr_q;
    word_d = word_q;
    vld_d  = 1'b0;
    if (!run) begin
      left_d = '0;
    end else if (fall_ev) begin
      if (left_q != '0) begin
        shr_d  = {shr_q[WORD_W-2:0], rx_dat};
        left_d = left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          word_d = {shr_q[WORD_W-2:0], rx_dat};
          vld_d  = 1'b1;
        end
      end else if (rx_sync) begin
        left_d = CNT_W'(WORD_W);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      shr_q  <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      shr_q  <= shr_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_word  = word_q;
  assign rx_valid = vld_q;

endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
  import fsp_pkg::*;
#(
  parameter int WORD_W         = 16,
  parameter int RATE_BASE_LOG2 = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_en,
  input  logic              cfg_we,
  input  logic [MDIV_W-1:0] cfg_mdiv,
  input  logic [SDIV_W-1:0] cfg_sdiv,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              rx_dat,
  input  logic              rx_sync,
  output logic              ser_clk,
  output logic              tx_dat,
  output logic              tx_dat_oe,
  output logic              tx_sync,
  output logic              tx_sync_oe,
  output logic              rate_stb,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);

  logic [1:0]             rst_pipe;
  logic                   rst_int_n;
  logic [SYNC_STAGES-1:0] en_pipe;
  logic                   run;
  fsp_cfg_t               cfg_q, cfg_d;
  logic                   rise_ev, fall_ev;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Enable synchronizer
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) en_pipe <= '0;
    else            en_pipe <= {en_pipe[SYNC_STAGES-2:0], host_en};
  end
  assign run = en_pipe[SYNC_STAGES-1];

  // Divider settings, kept while the port is disabled
  always_comb begin
    cfg_d = '{mdiv: cfg_mdiv, sdiv: cfg_sdiv, rate: cfg_rate};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  fsp_clkgen #(.RATE_BASE_LOG2(RATE_BASE_LOG2)) clkgen_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .cfg      (cfg_q),
    .ser_clk  (ser_clk),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .rate_stb (rate_stb)
  );

  fsp_tx #(.WORD_W(WORD_W)) tx_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (run),
    .rise_ev    (rise_ev),
    .rate_stb   (rate_stb),
    .tx_word    (tx_word),
    .tx_dat     (tx_dat),
    .tx_dat_oe  (tx_dat_oe),
    .tx_sync    (tx_sync),
    .tx_sync_oe (tx_sync_oe)
  );

  fsp_rx #(.WORD_W(WORD_W)) rx_i (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .fall_ev  (fall_ev),
    .rx_dat   (rx_dat),
    .rx_sync  (rx_sync),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

endmodule

// File: rtl/framed_serial_port_chk.sv
module framed_serial_port_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_en,
  input logic              ser_clk,
  input logic              tx_dat_oe,
  input logic              tx_sync,
  input logic              tx_sync_oe,
  input logic              rate_stb,
  input logic [WORD_W-1:0] rx_word,
  input logic              rx_valid
);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!ser_clk && !tx_dat_oe && !tx_sync_oe && !rx_valid && !rate_stb));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !$past(host_en) && !$past(host_en, 2) && !$past(host_en, 3))
      |-> (!ser_clk && !tx_dat_oe && !tx_sync_oe && !rx_valid && !rate_stb));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_stb |=> !rate_stb);

  // R5
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  word_moves_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_word) |-> rx_valid);

  // R4
  sync_data_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sync |-> !tx_dat_oe);

endmodule

bind framed_serial_port framed_serial_port_chk #(.WORD_W(WORD_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_en    (host_en),
  .ser_clk    (ser_clk),
  .tx_dat_oe  (tx_dat_oe),
  .tx_sync    (tx_sync),
  .tx_sync_oe (tx_sync_oe),
  .rate_stb   (rate_stb),
  .rx_word    (rx_word),
  .rx_valid   (rx_valid)
);

// File: tb/framed_serial_port_tb_top.sv
module framed_serial_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV         = 6;
  // fields: mdiv[38:36] sdiv[35:34] rate[33:32] tx[31:16] rx[15:0]
  localparam logic [38:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'd0, 16'hA5C3, 16'h3C5A},
    {3'd1, 2'd0, 2'd1, 16'h8001, 16'h0001},
    {3'd2, 2'd1, 2'd0, 16'hFFFF, 16'h0000},
    {3'd0, 2'd3, 2'd2, 16'h0000, 16'hFFFF},
    {3'd7, 2'd3, 2'd0, 16'h1234, 16'h8000},
    {3'd4, 2'd2, 2'd3, 16'hBEEF, 16'hCAFE}
  };

  logic        clk;
  logic        rst_n;
  logic        host_en;
  logic        cfg_we;
  logic [2:0]  cfg_mdiv;
  logic [1:0]  cfg_sdiv;
  logic [1:0]  cfg_rate;
  logic [15:0] tx_word;
  logic        rx_dat;
  logic        rx_sync;
  logic        ser_clk;
  logic        tx_dat;
  logic        tx_dat_oe;
  logic        tx_sync;
  logic        tx_sync_oe;
  logic        rate_stb;
  logic [15:0] rx_word;
  logic        rx_valid;

  int          checks = 0;
  int          errors = 0;
  int          vcount = 0;
  logic [15:0] last_rx = '0;

  framed_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .cfg_we(cfg_we),
    .cfg_mdiv(cfg_mdiv), .cfg_sdiv(cfg_sdiv), .cfg_rate(cfg_rate),
    .tx_word(tx_word), .rx_dat(rx_dat), .rx_sync(rx_sync),
    .ser_clk(ser_clk), .tx_dat(tx_dat), .tx_dat_oe(tx_dat_oe),
    .tx_sync(tx_sync), .tx_sync_oe(tx_sync_oe), .rate_stb(rate_stb),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (rx_valid) begin
      vcount  <= vcount + 1;
      last_rx <= rx_word;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next_rise();
    logic p;
    p = ser_clk;
    forever begin
      @(negedge clk);
      if (ser_clk && !p) break;
      p = ser_clk;
    end
  endtask

  task automatic measure_sclk(output int hi, output int per);
    int lo;
    while (ser_clk) @(negedge clk);
    while (!ser_clk) @(negedge clk);
    hi = 1;
    forever begin
      @(negedge clk);
      if (ser_clk) hi++;
      else break;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (!ser_clk) lo++;
      else break;
    end
    per = hi + lo;
  endtask

  task automatic measure_stb(output int per);
    while (!rate_stb) @(negedge clk);
    per = 0;
    do begin
      @(negedge clk);
      per++;
    end while (!rate_stb);
  endtask

  task automatic capture_tx(input logic [15:0] exp);
    logic [15:0] got;
    bit          oe_ok;
    got   = '0;
    oe_ok = 1'b1;
    do next_rise(); while (!tx_sync);
    chk(tx_sync_oe && !tx_dat_oe, "R4 idle before data", {30'd0, tx_sync_oe, tx_dat_oe}, 2);
    for (int i = 0; i < 16; i++) begin
      next_rise();
      if (i == 0) chk(!tx_sync, "R3 sync one period wide", int'(tx_sync), 0);
      if (!tx_dat_oe) oe_ok = 1'b0;
      got = {got[14:0], tx_dat};
    end
    chk(oe_ok, "R4 oe during data bits", int'(oe_ok), 1);
    chk(got == exp, "R3 transmitted word", int'(got), int'(exp));
    next_rise();
    chk(!tx_dat_oe, "R4 oe drops after word", int'(tx_dat_oe), 0);
  endtask

  task automatic send_rx(input logic [15:0] w, input bit hold_sync);
    next_rise();
    rx_sync = 1'b1;
    rx_dat  = 1'b0;
    for (int i = 0; i < 16; i++) begin
      next_rise();
      rx_sync = hold_sync;
      rx_dat  = w[15 - i];
    end
    next_rise();
    rx_sync = 1'b0;
    rx_dat  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int hi, per, base, n;
    logic [15:0] held;
    bit quiet;
    rst_n    = 1'b0;
    host_en  = 1'b1;
    cfg_we   = 1'b0;
    cfg_mdiv = '0;
    cfg_sdiv = '0;
    cfg_rate = '0;
    tx_word  = '0;
    rx_dat   = 1'b0;
    rx_sync  = 1'b0;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(!ser_clk && !tx_dat_oe && !tx_sync_oe && !rate_stb && !rx_valid,
        "R9 outputs low in reset", {27'd0, ser_clk, tx_dat_oe, tx_sync_oe, rate_stb, rx_valid}, 0);
    chk(rx_word == 16'h0, "R9 rx_word cleared", int'(rx_word), 0);
    rst_n = 1'b1;
    measure_sclk(hi, per);
    chk(per == 2, "R9 default sclk period", per, 2);
    measure_stb(per);
    chk(per == 256, "R9 default strobe period", per, 256);

    // Vector table: R1 R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      host_en = 1'b0;
      cfg_mdiv = VEC[v][38:36];
      cfg_sdiv = VEC[v][35:34];
      cfg_rate = VEC[v][33:32];
      tx_word  = VEC[v][31:16];
      cfg_we   = 1'b1;
      @(negedge clk);
      cfg_we   = 1'b0;
      repeat (4) @(negedge clk);
      host_en = 1'b1;
      base = (int'(VEC[v][38:36]) + 1) << (int'(VEC[v][35:34]) + 1);
      measure_sclk(hi, per);
      chk(per == base, "R1 sclk period", per, base);
      chk(hi == base / 2, "R1 sclk high time", hi, base / 2);
      measure_stb(per);
      chk(per == (256 << VEC[v][33:32]), "R2 strobe period", per, 256 << VEC[v][33:32]);
      capture_tx(VEC[v][31:16]);
      n = vcount;
      send_rx(VEC[v][15:0], 1'b0);
      chk(vcount == n + 1, "R5 one valid pulse", vcount - n, 1);
      chk(last_rx == VEC[v][15:0], "R5 received word", int'(last_rx), int'(VEC[v][15:0]));
    end

    // R6 sync held high during the whole word
    n = vcount;
    send_rx(16'h6D29, 1'b1);
    chk(vcount == n + 1, "R6 single valid with sync held", vcount - n, 1);
    chk(last_rx == 16'h6D29, "R6 word intact with sync held", int'(last_rx), 16'h6D29);

    // R7 disabled port is quiet and ignores inputs
    held = rx_word;
    n    = vcount;
    host_en = 1'b0;
    repeat (4) @(negedge clk);
    quiet = 1'b1;
    for (int i = 0; i < 300; i++) begin
      rx_sync = i[0];
      rx_dat  = i[1];
      @(negedge clk);
      if (ser_clk || tx_dat_oe || tx_sync_oe || rate_stb || rx_valid) quiet = 1'b0;
    end
    rx_sync = 1'b0;
    rx_dat  = 1'b0;
    chk(quiet, "R7 outputs quiet while disabled", int'(quiet), 1);
    chk(vcount == n, "R7 inputs ignored while disabled", vcount - n, 0);

    // R8 restart: counters from zero, settings and word kept
    host_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rate_stb);
    chk(n == (256 << 3) + 1, "R8 first strobe after enable", n, (256 << 3) + 1);
    chk(rx_word == held, "R8 rx_word kept", int'(rx_word), int'(held));
    measure_sclk(hi, per);
    chk(per == 40, "R8 divider settings kept", per, 40);

    // R10 fields ignored without write enable
    cfg_mdiv = 3'd0;
    cfg_sdiv = 2'd0;
    repeat (3) @(negedge clk);
    measure_sclk(hi, per);
    chk(per == 40, "R10 no store without cfg_we", per, 40);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    measure_sclk(hi, per);
    chk(per == 2, "R10 store with cfg_we", per, 2);

    // R9 reset during operation
    rst_n = 1'b0;
    @(negedge clk);
    chk(rx_word == 16'h0 && !ser_clk && !tx_sync_oe, "R9 mid-run reset clears",
        int'(rx_word), 0);
    cfg_mdiv = 3'd5;
    rst_n = 1'b1;
    measure_sclk(hi, per);
    chk(per == 2, "R9 settings cleared by reset", per, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule